// File: doc/BRIEF.md
# Burst-of-Four Double-Data-Rate SRAM Core

This block is a synthesizable model of a synchronous SRAM with a shared data path that moves every access as a burst of four beats, two per clock cycle. The two edges of the external clock are modelled inside one clock domain: each cycle carries a "rise" beat and a "fall" beat on separate ports. A command is loaded with an active-low strobe, a read/write select and a word address. The storage array is four beats wide. Write beats are gathered into one wide word and stored in a single step under per-lane byte enables. A read fetches one wide word and hands it out as four beats.

The two lowest address bits choose which beat of the wide word is transferred first. The order then wraps linearly, so any word of the burst can come first. A build option turns this off for narrow configurations. In that case those two bits are ignored and every burst starts at beat position 0. A write is committed one cycle after its last beat. A read issued in that cycle still sees the new data through a bypass path.

Top module: `b4sram_core`

## Requirements
- R1: A command is accepted at a rising edge where `ld_n` is 0 and no burst is in progress. `rd_wr` = 1 selects a read and 0 selects a write. The array row is `addr[ADDR_W-1:2]`.
- R2: A write takes transfer 0 on `wd_rise` and transfer 1 on `wd_fall` in the cycle of the command. It takes transfers 2 and 3 in the next cycle. Transfer k is stored at beat position (start + k) mod 4 of the row. Position p occupies row bits [p*DATA_W +: DATA_W]. All four positions are written together.
- R3: With `CWF` = 1 the start position is `addr[1:0]`. Read data is returned in the order start, start+1, start+2, start+3 (mod 4), each cycle giving the earlier beat on the rise port and the later one on the fall port.
- R4: With `CWF` = 0, `addr[1:0]` has no effect and every burst, read or write, starts at position 0.
- R5: Each transfer has one active-low enable per lane. Lane l covers beat bits [l*LANE_W +: LANE_W]. A lane whose enable is 1 keeps its stored value.
- R6: A read accepted in the cycle right after a write's last transfers returns the newly written data, merged under that write's lane enables.
- R7: The first beat pair of a read is on `rd_rise`/`rd_fall` after RD_LAT rising edges, counting the edge that accepted the command. The second pair follows one cycle later. `rvld_rise` and `rvld_fall` are both 1 in exactly those two cycles.
- R8: A load issued in the cycle after an accepted load raises `cmd_err` for one cycle after that edge. That load has no effect: it writes nothing and returns no read data.
- R9: While `rst` is held and after it, `rvld_rise`, `rvld_fall` and `cmd_err` are 0 and no burst is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each cycle carries two beats |
| rst | input | 1 | Synchronous reset, active high |
| ld_n | input | 1 | Load strobe, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word address; low two bits pick the first beat |
| wd_rise | input | DATA_W | Write beat for the first half of the cycle |
| wd_fall | input | DATA_W | Write beat for the second half of the cycle |
| we_n_rise | input | LANES | Active-low lane enables for `wd_rise` |
| we_n_fall | input | LANES | Active-low lane enables for `wd_fall` |
| rd_rise | output | DATA_W | Read beat, first half of the cycle |
| rd_fall | output | DATA_W | Read beat, second half of the cycle |
| rvld_rise | output | 1 | `rd_rise` carries valid data |
| rvld_fall | output | 1 | `rd_fall` carries valid data |
| cmd_err | output | 1 | A load arrived while a burst was in progress |

## Verification
The embedded properties are checked on every cycle. They cover the following:
- No two commands are accepted on adjacent edges.
- `cmd_err` only follows a low load strobe.
- A staged write is committed in a single cycle.
- The two valid flags always agree, and each read produces at least two valid cycles.

The data-dependent behaviour can only be shown by the bench's scenarios, which compare every read beat against a reference model. This covers the wrap order for all four start positions, where write transfers land, partial lane writes, the read-after-write bypass, the narrow mode that ignores the low address bits, and the fact that a rejected command leaves the stored data untouched.

// File: rtl/b4sram_pkg.sv
package b4sram_pkg;

    localparam int BEATS = 4;
    localparam int PTR_W = 2;

    typedef logic [PTR_W-1:0] ptr_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Beat position of transfer k in a burst that starts at position start (wraps mod 4)
    function automatic ptr_t beat_slot(input ptr_t start, input ptr_t k);
        return ptr_t'(start + k);
    endfunction

endpackage

// File: rtl/b4sram_cmd_ctrl.sv
module b4sram_cmd_ctrl
    import b4sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter bit CWF    = 1'b1,
    localparam int IDX_W = ADDR_W - PTR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_n,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr,
    output op_e               op_first,
    output op_e               op_second,
    output ptr_t              start_cur,
    output ptr_t              start_hold,
    output logic [IDX_W-1:0]  idx_cur,
    output logic [IDX_W-1:0]  idx_hold,
    output logic              cmd_err
);

    op_e  op_hold;
    logic busy;
    logic accept;

    assign busy      = (op_hold != OP_IDLE);
    assign accept    = !ld_n && !busy;
    assign op_first  = accept ? (rd_wr ? OP_READ : OP_WRITE) : OP_IDLE;
    assign op_second = op_hold;
    assign idx_cur   = addr[ADDR_W-1:PTR_W];

    generate
        if (CWF) begin : g_cwf
            assign start_cur = addr[PTR_W-1:0];
        end else begin : g_linear
            assign start_cur = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            op_hold <= OP_IDLE;
            cmd_err <= 1'b0;
        end else begin
            op_hold <= op_first;
            cmd_err <= !ld_n && busy;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            start_hold <= start_cur;
            idx_hold   <= idx_cur;
        end
    end

    // R1 / R8: an accepted command blocks acceptance on the very next edge
    assert_one_issue_R8: assert property (@(posedge clk) disable iff (rst)
        (op_first != OP_IDLE) |=> (op_first == OP_IDLE));

endmodule

// File: rtl/b4sram_wr_gather.sv
module b4sram_wr_gather
    import b4sram_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int IDX_W  = 6,
    localparam int DATA_W = LANE_W * LANES,
    localparam int WORD_W = BEATS * DATA_W,
    localparam int KEEP_W = BEATS * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op_first,
    input  op_e               op_second,
    input  ptr_t              start_cur,
    input  ptr_t              start_hold,
    input  logic [IDX_W-1:0]  idx_hold,
    input  logic [DATA_W-1:0] wd_rise,
    input  logic [DATA_W-1:0] wd_fall,
    input  logic [LANES-1:0]  we_n_rise,
    input  logic [LANES-1:0]  we_n_fall,
    output logic              pend_vld,
    output logic [IDX_W-1:0]  pend_idx,
    output logic [WORD_W-1:0] pend_data,
    output logic [KEEP_W-1:0] pend_keep
);

    logic [WORD_W-1:0] col_data, fin_data;
    logic [KEEP_W-1:0] col_keep, fin_keep;
    ptr_t s0, s1, s2, s3;

    assign s0 = beat_slot(start_cur, 2'd0);
    assign s1 = beat_slot(start_cur, 2'd1);
    assign s2 = beat_slot(start_hold, 2'd2);
    assign s3 = beat_slot(start_hold, 2'd3);

    // Final wide word: first half from the collector, second half straight from the bus
    always_comb begin
        fin_data = col_data;
        fin_keep = col_keep;
        for (int b = 0; b < BEATS; b++) begin
            if (ptr_t'(b) == s2) begin
                fin_data[b*DATA_W +: DATA_W] = wd_rise;
                fin_keep[b*LANES +: LANES]   = ~we_n_rise;
            end
            if (ptr_t'(b) == s3) begin
                fin_data[b*DATA_W +: DATA_W] = wd_fall;
                fin_keep[b*LANES +: LANES]   = ~we_n_fall;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (op_first == OP_WRITE) begin
            for (int b = 0; b < BEATS; b++) begin
                if (ptr_t'(b) == s0) begin
                    col_data[b*DATA_W +: DATA_W] <= wd_rise;
                    col_keep[b*LANES +: LANES]   <= ~we_n_rise;
                end
                if (ptr_t'(b) == s1) begin
                    col_data[b*DATA_W +: DATA_W] <= wd_fall;
                    col_keep[b*LANES +: LANES]   <= ~we_n_fall;
                end
            end
        end
        if (op_second == OP_WRITE) begin
            pend_data <= fin_data;
            pend_keep <= fin_keep;
            pend_idx  <= idx_hold;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_vld <= 1'b0;
        else     pend_vld <= (op_second == OP_WRITE);
    end

    // R2: a gathered word is staged for exactly one commit cycle
    assert_single_commit_R2: assert property (@(posedge clk) disable iff (rst)
        pend_vld |=> !pend_vld);

endmodule

// File: rtl/b4sram_array.sv
module b4sram_array
    import b4sram_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int IDX_W  = 6,
    localparam int DATA_W = LANE_W * LANES,
    localparam int WORD_W = BEATS * DATA_W,
    localparam int KEEP_W = BEATS * LANES,
    localparam int DEPTH  = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              pend_vld,
    input  logic [IDX_W-1:0]  pend_idx,
    input  logic [WORD_W-1:0] pend_data,
    input  logic [KEEP_W-1:0] pend_keep,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] old_w, base_w, wr_merged;
    logic              hit;

    assign old_w  = mem[pend_idx];
    assign base_w = mem[rd_idx];
    assign hit    = pend_vld && (pend_idx == rd_idx);

    generate
        for (genvar j = 0; j < KEEP_W; j++) begin : g_lane
            assign wr_merged[j*LANE_W +: LANE_W] =
                pend_keep[j] ? pend_data[j*LANE_W +: LANE_W] : old_w[j*LANE_W +: LANE_W];
            // Coherent read: a staged write to the same row wins, lane by lane
            assign rd_word[j*LANE_W +: LANE_W] =
                (hit && pend_keep[j]) ? pend_data[j*LANE_W +: LANE_W] : base_w[j*LANE_W +: LANE_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (pend_vld) mem[pend_idx] <= wr_merged;
    end

endmodule

// File: rtl/b4sram_rd_serial.sv
module b4sram_rd_serial
    import b4sram_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int RD_LAT = 2,
    localparam int DATA_W = LANE_W * LANES,
    localparam int WORD_W = BEATS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op_first,
    input  op_e               op_second,
    input  ptr_t              start_cur,
    input  ptr_t              start_hold,
    input  logic [WORD_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_rise,
    output logic [DATA_W-1:0] rd_fall,
    output logic              rvld_rise,
    output logic              rvld_fall
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] r;
        logic [DATA_W-1:0] f;
    } stage_t;

    stage_t              st_n;
    stage_t [RD_LAT-1:0] pipe;
    logic [WORD_W-1:0]   word_q;
    ptr_t                s0, s1, s2, s3;

    assign s0 = beat_slot(start_cur, 2'd0);
    assign s1 = beat_slot(start_cur, 2'd1);
    assign s2 = beat_slot(start_hold, 2'd2);
    assign s3 = beat_slot(start_hold, 2'd3);

    always_comb begin
        st_n = '0;
        if (op_first == OP_READ) begin
            st_n.vld = 1'b1;
            st_n.r   = rd_word[s0*DATA_W +: DATA_W];
            st_n.f   = rd_word[s1*DATA_W +: DATA_W];
        end else if (op_second == OP_READ) begin
            st_n.vld = 1'b1;
            st_n.r   = word_q[s2*DATA_W +: DATA_W];
            st_n.f   = word_q[s3*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (op_first == OP_READ) word_q <= rd_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe[0] <= st_n;
            for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign rd_rise   = pipe[RD_LAT-1].r;
    assign rd_fall   = pipe[RD_LAT-1].f;
    assign rvld_rise = pipe[RD_LAT-1].vld;
    assign rvld_fall = pipe[RD_LAT-1].vld;

    // R7: both halves are flagged together, and a read burst spans two cycles
    assert_vld_pair_R7: assert property (@(posedge clk) disable iff (rst)
        rvld_rise == rvld_fall);
    assert_burst_two_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rvld_rise) |=> rvld_rise);

endmodule

// File: rtl/b4sram_core.sv
module b4sram_core
    import b4sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int RD_LAT = 2,
    parameter bit CWF    = 1'b1,
    localparam int DATA_W = LANE_W * LANES,
    localparam int WORD_W = BEATS * DATA_W,
    localparam int KEEP_W = BEATS * LANES,
    localparam int IDX_W  = ADDR_W - PTR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_n,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wd_rise,
    input  logic [DATA_W-1:0] wd_fall,
    input  logic [LANES-1:0]  we_n_rise,
    input  logic [LANES-1:0]  we_n_fall,
    output logic [DATA_W-1:0] rd_rise,
    output logic [DATA_W-1:0] rd_fall,
    output logic              rvld_rise,
    output logic              rvld_fall,
    output logic              cmd_err
);

    op_e               op_first, op_second;
    ptr_t              start_cur, start_hold;
    logic [IDX_W-1:0]  idx_cur, idx_hold, pend_idx;
    logic              pend_vld;
    logic [WORD_W-1:0] pend_data, rd_word;
    logic [KEEP_W-1:0] pend_keep;

    b4sram_cmd_ctrl #(.ADDR_W(ADDR_W), .CWF(CWF)) u_cmd (
        .clk(clk), .rst(rst), .ld_n(ld_n), .rd_wr(rd_wr), .addr(addr),
        .op_first(op_first), .op_second(op_second),
        .start_cur(start_cur), .start_hold(start_hold),
        .idx_cur(idx_cur), .idx_hold(idx_hold), .cmd_err(cmd_err)
    );

    b4sram_wr_gather #(.LANE_W(LANE_W), .LANES(LANES), .IDX_W(IDX_W)) u_wr (
        .clk(clk), .rst(rst), .op_first(op_first), .op_second(op_second),
        .start_cur(start_cur), .start_hold(start_hold), .idx_hold(idx_hold),
        .wd_rise(wd_rise), .wd_fall(wd_fall),
        .we_n_rise(we_n_rise), .we_n_fall(we_n_fall),
        .pend_vld(pend_vld), .pend_idx(pend_idx),
        .pend_data(pend_data), .pend_keep(pend_keep)
    );

    b4sram_array #(.LANE_W(LANE_W), .LANES(LANES), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .pend_vld(pend_vld), .pend_idx(pend_idx),
        .pend_data(pend_data), .pend_keep(pend_keep),
        .rd_idx(idx_cur), .rd_word(rd_word)
    );

    b4sram_rd_serial #(.LANE_W(LANE_W), .LANES(LANES), .RD_LAT(RD_LAT)) u_rd (
        .clk(clk), .rst(rst), .op_first(op_first), .op_second(op_second),
        .start_cur(start_cur), .start_hold(start_hold), .rd_word(rd_word),
        .rd_rise(rd_rise), .rd_fall(rd_fall),
        .rvld_rise(rvld_rise), .rvld_fall(rvld_fall)
    );

    // R8: an error flag is only raised by a load strobe on the previous edge
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $past(!ld_n));

endmodule

// File: tb/b4sram_core_tb.sv
module b4sram_core_tb;

    localparam int ADDR_W = 8;
    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int RD_LAT = 2;
    localparam int DATA_W = LANE_W * LANES;
    localparam int ROWS   = 1 << (ADDR_W - 2);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              ld_n = 1'b1, rd_wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wd_rise = '0, wd_fall = '0;
    logic [LANES-1:0]  we_n_rise = '1, we_n_fall = '1;
    logic [DATA_W-1:0] rd_rise, rd_fall;
    logic              rvld_rise, rvld_fall, cmd_err;

    logic              n_ld_n = 1'b1, n_rd_wr = 1'b0;
    logic [ADDR_W-1:0] n_addr = '0;
    logic [DATA_W-1:0] n_wd_rise = '0, n_wd_fall = '0;
    logic [LANES-1:0]  n_we_n_rise = '1, n_we_n_fall = '1;
    logic [DATA_W-1:0] n_rd_rise, n_rd_fall;
    logic              n_rvld_rise, n_rvld_fall, n_cmd_err;

    b4sram_core #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES), .RD_LAT(RD_LAT), .CWF(1'b1)) u_dut (
        .clk(clk), .rst(rst), .ld_n(ld_n), .rd_wr(rd_wr), .addr(addr),
        .wd_rise(wd_rise), .wd_fall(wd_fall), .we_n_rise(we_n_rise), .we_n_fall(we_n_fall),
        .rd_rise(rd_rise), .rd_fall(rd_fall), .rvld_rise(rvld_rise), .rvld_fall(rvld_fall),
        .cmd_err(cmd_err)
    );

    b4sram_core #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES), .RD_LAT(RD_LAT), .CWF(1'b0)) u_dut_nc (
        .clk(clk), .rst(rst), .ld_n(n_ld_n), .rd_wr(n_rd_wr), .addr(n_addr),
        .wd_rise(n_wd_rise), .wd_fall(n_wd_fall), .we_n_rise(n_we_n_rise), .we_n_fall(n_we_n_fall),
        .rd_rise(n_rd_rise), .rd_fall(n_rd_fall), .rvld_rise(n_rvld_rise), .rvld_fall(n_rvld_fall),
        .cmd_err(n_cmd_err)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int                at;
        logic [DATA_W-1:0] r;
        logic [DATA_W-1:0] f;
    } exp_t;
    exp_t q[$];

    logic [DATA_W-1:0] refm [ROWS][4];

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pat(input int row, input int p, input int salt);
        return DATA_W'(row * 97 + p * 29 + salt * 1031 + 5);
    endfunction

    task automatic apply(input int row, input logic [1:0] pos, input logic [DATA_W-1:0] d, input logic [LANES-1:0] m_n);
        for (int l = 0; l < LANES; l++)
            if (!m_n[l]) refm[row][pos][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
    endtask

    // Driver: write burst (called at a falling edge)
    task automatic do_write(input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] d0, d1, d2, d3,
                            input logic [LANES-1:0] m0, m1, m2, m3);
        logic [1:0] s;
        int row;
        s = a[1:0];
        row = int'(a[ADDR_W-1:2]);
        ld_n = 1'b0; rd_wr = 1'b0; addr = a;
        wd_rise = d0; wd_fall = d1; we_n_rise = m0; we_n_fall = m1;
        @(negedge clk);
        ld_n = 1'b1;
        wd_rise = d2; wd_fall = d3; we_n_rise = m2; we_n_fall = m3;
        apply(row, s, d0, m0);
        apply(row, s + 2'd1, d1, m1);
        apply(row, s + 2'd2, d2, m2);
        apply(row, s + 2'd3, d3, m3);
        @(negedge clk);
        wd_rise = '0; wd_fall = '0; we_n_rise = '1; we_n_fall = '1;
    endtask

    // Driver: read burst; pushes expected beat pairs with their arrival cycles
    task automatic do_read(input logic [ADDR_W-1:0] a);
        logic [1:0] s;
        int row;
        exp_t e;
        s = a[1:0];
        row = int'(a[ADDR_W-1:2]);
        ld_n = 1'b0; rd_wr = 1'b1; addr = a;
        @(negedge clk);
        e.at = cyc + RD_LAT - 1; e.r = refm[row][s];         e.f = refm[row][s + 2'd1]; q.push_back(e);
        e.at = cyc + RD_LAT;     e.r = refm[row][s + 2'd2]; e.f = refm[row][s + 2'd3]; q.push_back(e);
        ld_n = 1'b1;
        @(negedge clk);
    endtask

    // Monitor: scoreboard compare of read beats (R3 R6 R7)
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rvld_rise !== rvld_fall)
                chk(1'b0, "R7 valid flags differ", 64'(rvld_fall), 64'(rvld_rise));
            if (rvld_rise === 1'b1) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R8 unexpected read data", 64'(rd_rise), 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc == e.at, "R7 read beat timing", 64'(cyc), 64'(e.at));
                    chk(rd_rise === e.r, "R3 R6 rise beat", 64'(rd_rise), 64'(e.r));
                    chk(rd_fall === e.f, "R3 R6 fall beat", 64'(rd_fall), 64'(e.f));
                end
            end else if (q.size() > 0 && q[0].at <= cyc) begin
                exp_t e;
                e = q.pop_front();
                chk(1'b0, "R7 missing read beat", 64'(cyc), 64'(e.at));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int p = 0; p < 4; p++) refm[r][p] = '0;

        repeat (3) @(negedge clk);
        // R9: reset state
        chk(rvld_rise == 1'b0 && rvld_fall == 1'b0, "R9 valid low in reset", 64'(rvld_rise), 64'd0);
        chk(cmd_err == 1'b0, "R9 error low in reset", 64'(cmd_err), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(rvld_rise == 1'b0 && cmd_err == 1'b0, "R9 quiet after reset", 64'({rvld_rise, cmd_err}), 64'd0);

        // R1 R2: fill rows 0..7 with full writes, start position 0
        for (int r = 0; r < 8; r++)
            do_write(ADDR_W'(r * 4), pat(r,0,0), pat(r,1,0), pat(r,2,0), pat(r,3,0), '0, '0, '0, '0);

        // R3: reads of row 1 from every start position
        for (int s = 0; s < 4; s++) do_read(ADDR_W'(4 + s));

        // R2: write to row 2 starting at position 2, read back linearly and wrapped
        do_write(ADDR_W'(8 + 2), pat(2,0,1), pat(2,1,1), pat(2,2,1), pat(2,3,1), '0, '0, '0, '0);
        do_read(ADDR_W'(8));
        do_read(ADDR_W'(8 + 3));

        // R5: partial lane writes on row 3
        do_write(ADDR_W'(12 + 1), pat(3,0,2), pat(3,1,2), pat(3,2,2), pat(3,3,2), 2'b01, 2'b10, 2'b11, 2'b00);
        do_read(ADDR_W'(12));
        do_write(ADDR_W'(12), pat(3,0,3), pat(3,1,3), pat(3,2,3), pat(3,3,3), 2'b11, 2'b11, 2'b11, 2'b11);
        do_read(ADDR_W'(12 + 2));

        // R6: read in the cycle right after the last write beats, same row, partial lanes
        do_write(ADDR_W'(20 + 3), pat(5,0,4), pat(5,1,4), pat(5,2,4), pat(5,3,4), 2'b10, 2'b00, 2'b01, 2'b00);
        do_read(ADDR_W'(20 + 1));
        // R6: back-to-back write then read of a different row is unaffected
        do_write(ADDR_W'(24), pat(6,0,5), pat(6,1,5), pat(6,2,5), pat(6,3,5), '0, '0, '0, '0);
        do_read(ADDR_W'(28));

        // R8: load during a burst is flagged and ignored
        ld_n = 1'b0; rd_wr = 1'b1; addr = ADDR_W'(4);
        @(negedge clk);
        begin
            exp_t e;
            e.at = cyc + RD_LAT - 1; e.r = refm[1][0]; e.f = refm[1][1]; q.push_back(e);
            e.at = cyc + RD_LAT;     e.r = refm[1][2]; e.f = refm[1][3]; q.push_back(e);
        end
        rd_wr = 1'b0; addr = ADDR_W'(16);
        wd_rise = 18'h3ffff; wd_fall = 18'h3ffff; we_n_rise = '0; we_n_fall = '0;
        @(negedge clk);
        chk(cmd_err == 1'b1, "R8 error raised", 64'(cmd_err), 64'd1);
        ld_n = 1'b1; wd_rise = '0; wd_fall = '0; we_n_rise = '1; we_n_fall = '1;
        @(negedge clk);
        chk(cmd_err == 1'b0, "R8 error lasts one cycle", 64'(cmd_err), 64'd0);
        do_read(ADDR_W'(16));   // R8: row 4 must still hold its earlier data

        repeat (RD_LAT + 3) @(negedge clk);
        chk(q.size() == 0, "R7 all read beats delivered", 64'(q.size()), 64'd0);

        // R4: narrow mode ignores addr[1:0]
        n_ld_n = 1'b0; n_rd_wr = 1'b0; n_addr = ADDR_W'(4 + 2);
        n_wd_rise = 18'h0a0a1; n_wd_fall = 18'h0b0b2; n_we_n_rise = '0; n_we_n_fall = '0;
        @(negedge clk);
        n_ld_n = 1'b1; n_wd_rise = 18'h0c0c3; n_wd_fall = 18'h0d0d4;
        @(negedge clk);
        n_we_n_rise = '1; n_we_n_fall = '1;
        n_ld_n = 1'b0; n_rd_wr = 1'b1; n_addr = ADDR_W'(4 + 3);
        @(negedge clk);
        n_ld_n = 1'b1;
        repeat (RD_LAT - 1) @(negedge clk);
        chk(n_rvld_rise == 1'b1, "R4 narrow read valid", 64'(n_rvld_rise), 64'd1);
        chk(n_rd_rise == 18'h0a0a1 && n_rd_fall == 18'h0b0b2, "R4 narrow first pair",
            64'({n_rd_rise, n_rd_fall}), 64'({18'h0a0a1, 18'h0b0b2}));
        @(negedge clk);
        chk(n_rd_rise == 18'h0c0c3 && n_rd_fall == 18'h0d0d4, "R4 narrow second pair",
            64'({n_rd_rise, n_rd_fall}), 64'({18'h0c0c3, 18'h0d0d4}));
        @(negedge clk);
        chk(n_rvld_rise == 1'b0 && n_cmd_err == 1'b0, "R4 narrow burst ends", 64'({n_rvld_rise, n_cmd_err}), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule